// File: doc/BRIEF.md
# Read Port Undefined-Value Randomizer

This block sits on the output of one read port of a memory whose read latency is zero or one cycle. It watches the read request together with the activity of every write port. Whenever the value the port is about to return has no defined meaning, it swaps the raw memory word for a pseudo-random word. A model checker or simulator downstream then cannot depend on whatever the memory array happens to hold in those cases.

Three situations make a read undefined:
- the address lies outside the populated range of a memory whose depth is not a power of two;
- the read enable is low;
- an active write port targets the same address in the same cycle, when the read-under-write policy is undefined.

Each cause has its own enable parameter. A cause that cannot arise in a given configuration is pruned at elaboration:
- out-of-range detection only exists when the depth is not a power of two;
- the disabled-read cause is dropped when the enable is declared tied high;
- collisions only count when read and write latencies match.

The combined flag is delayed to line up with the read data before it drives the output multiplexer. Configurations with a write latency other than one, a read latency above one, or a zero seed stop elaboration.

Top module: `rd_undef_scrambler`

## Requirements
- R1: With OOB_EN set and DEPTH not a power of two, an enabled read whose address is DEPTH or more is randomized, and address DEPTH-1 is not.
- R2: With DIS_EN set and RD_EN_TIED clear, a read with rd_en low is randomized whatever its address or the write activity.
- R3: With RWC_EN and RUW_UNDEF set and RD_LAT equal to WR_LAT, an enabled read is randomized when, for some port i, bit i of wr_act is high and slice i (bits i*ADDR_W upward) of wr_addr equals rd_addr. An inactive port or a differing address causes nothing.
- R4: When no cause applies, rdata_out equals mem_rdata unchanged in the same cycle.
- R5: With RD_LAT=1, the decision for a read presented before a rising edge governs rdata_out during the following cycle. With RD_LAT=0, it governs rdata_out in the same cycle, combinationally.
- R6: The random word is the current state of a DATA_W-bit shift register. At each rising edge where the aligned flag is high, it moves one step: shift left by one, and the new bit 0 is the XOR of the state bits selected by TAPS (default bits 15, 13, 12, 10). Otherwise it holds.
- R7: An active-low asynchronous rst_n loads the shift register with SEED (default 16'hACE1) and clears the delayed flag.
- R8: Cause enables are independent. With RD_LAT=0 and a write latency of one, a collision is never randomized; with DIS_EN clear, a disabled read passes mem_rdata through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| mem_rdata | input | DATA_W | Raw word from the memory array, aligned with the output cycle |
| wr_act | input | NUM_WR | Per write port: enable and mask both high |
| wr_addr | input | NUM_WR*ADDR_W | Write addresses, port i in slice i |
| rdata_out | output | DATA_W | Read word, randomized when undefined |

## Verification
Two instances run on shared stimulus:
- a one-cycle-latency instance with all causes live;
- a zero-latency instance with DEPTH 12 and only the range cause.

The vector table separates in-range from out-of-range addresses at the DEPTH-1/DEPTH boundary and beyond it. It also separates a disabled read from an enabled one. Collisions are split into four patterns: an active same-address write on each port, an inactive same-address write, and active writes elsewhere. Comparing the two instances on the same patterns shows the same-cycle against next-cycle alignment, and that collisions and disabled reads are pruned in the second. Runs of consecutive randomized reads followed by a reset in the middle check the step order and the return to the seed.

// File: rtl/rd_undef_pkg.sv
package rd_undef_pkg;

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic bit latency_ok(input int rd_lat, input int wr_lat);
        return (wr_lat == 1) && (rd_lat >= 0) && (rd_lat <= 1);
    endfunction

endpackage

// File: rtl/rd_undef_cause_detect.sv
module rd_undef_cause_detect
    import rd_undef_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DEPTH      = 12,
    parameter int NUM_WR     = 2,
    parameter bit OOB_LIVE   = 1'b1,
    parameter bit DIS_LIVE   = 1'b1,
    parameter bit RWC_LIVE   = 1'b1,
    parameter bit RD_EN_TIED = 1'b0
) (
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [NUM_WR-1:0]        wr_act,
    input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
    output logic                     flag_raw
);
    localparam logic [ADDR_W:0] LIMIT = DEPTH[ADDR_W:0];

    logic eff_en;
    logic hit_oob;
    logic hit_dis;
    logic hit_rwc;

    generate
        if (RD_EN_TIED) begin : g_tied
            assign eff_en = 1'b1;
        end else begin : g_live_en
            assign eff_en = rd_en;
        end

        if (OOB_LIVE) begin : g_oob
            assign hit_oob = eff_en && ({1'b0, rd_addr} >= LIMIT);
        end else begin : g_no_oob
            assign hit_oob = 1'b0;
        end

        if (DIS_LIVE && !RD_EN_TIED) begin : g_dis
            assign hit_dis = !rd_en;
        end else begin : g_no_dis
            assign hit_dis = 1'b0;
        end

        if (RWC_LIVE) begin : g_rwc
            logic [NUM_WR-1:0] port_hit;
            for (genvar i = 0; i < NUM_WR; i++) begin : g_port
                assign port_hit[i] = wr_act[i] && (wr_addr[i*ADDR_W +: ADDR_W] == rd_addr);
            end
            assign hit_rwc = eff_en && (|port_hit);
        end else begin : g_no_rwc
            assign hit_rwc = 1'b0;
        end
    endgenerate

    assign flag_raw = hit_oob | hit_dis | hit_rwc;

endmodule

// File: rtl/rd_undef_flag_pipe.sv
module rd_undef_flag_pipe #(
    parameter int RD_LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_raw,
    output logic flag_dly
);
    generate
        if (RD_LAT == 0) begin : g_comb
            assign flag_dly = flag_raw;
        end else begin : g_reg
            typedef struct packed {
                logic [RD_LAT-1:0] stage;
            } pipe_t;

            pipe_t pipe_d;
            pipe_t pipe_q;

            always_comb begin
                pipe_d = pipe_q;
                if (RD_LAT == 1) begin
                    pipe_d.stage[0] = flag_raw;
                end else begin
                    pipe_d.stage = {pipe_q.stage[RD_LAT-2:0], flag_raw};
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q <= pipe_d;
                end
            end

            assign flag_dly = pipe_q.stage[RD_LAT-1];
        end
    endgenerate

endmodule

// File: rtl/rd_undef_lfsr.sv
module rd_undef_lfsr #(
    parameter int               W    = 16,
    parameter logic [W-1:0]     TAPS = 16'hB400,
    parameter logic [W-1:0]     SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    output logic [W-1:0] value
);
    typedef struct packed {
        logic [W-1:0] state;
    } lfsr_t;

    lfsr_t lfsr_d;
    lfsr_t lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (advance) begin
            lfsr_d.state = {lfsr_q.state[W-2:0], ^(lfsr_q.state & TAPS)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q.state <= SEED;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    assign value = lfsr_q.state;

endmodule

// File: rtl/rd_undef_scrambler.sv
module rd_undef_scrambler
    import rd_undef_pkg::*;
#(
    parameter int                DEPTH      = 12,
    parameter int                ADDR_W     = 4,
    parameter int                DATA_W     = 16,
    parameter int                NUM_WR     = 2,
    parameter int                RD_LAT     = 1,
    parameter int                WR_LAT     = 1,
    parameter bit                RUW_UNDEF  = 1'b1,
    parameter bit                RD_EN_TIED = 1'b0,
    parameter bit                OOB_EN     = 1'b1,
    parameter bit                DIS_EN     = 1'b1,
    parameter bit                RWC_EN     = 1'b1,
    parameter logic [DATA_W-1:0] TAPS       = 16'hB400,
    parameter logic [DATA_W-1:0] SEED       = 16'hACE1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [DATA_W-1:0]        mem_rdata,
    input  logic [NUM_WR-1:0]        wr_act,
    input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0]        rdata_out
);
    localparam bit OOB_LIVE = OOB_EN && !is_pow2(DEPTH);
    localparam bit RWC_LIVE = RWC_EN && RUW_UNDEF && (RD_LAT == WR_LAT);
    localparam bit DIS_LIVE = DIS_EN && !RD_EN_TIED;

    generate
        if (!latency_ok(RD_LAT, WR_LAT)) begin : g_bad_latency
            $error("rd_undef_scrambler: write latency must be 1 and read latency 0 or 1");
        end
        if (SEED == '0) begin : g_bad_seed
            $error("rd_undef_scrambler: SEED must be nonzero");
        end
    endgenerate

    logic              flag_raw;
    logic              flag_dly;
    logic [DATA_W-1:0] rnd_val;

    rd_undef_cause_detect #(
        .ADDR_W    (ADDR_W),
        .DEPTH     (DEPTH),
        .NUM_WR    (NUM_WR),
        .OOB_LIVE  (OOB_LIVE),
        .DIS_LIVE  (DIS_LIVE),
        .RWC_LIVE  (RWC_LIVE),
        .RD_EN_TIED(RD_EN_TIED)
    ) u_detect (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .wr_act  (wr_act),
        .wr_addr (wr_addr),
        .flag_raw(flag_raw)
    );

    rd_undef_flag_pipe #(
        .RD_LAT(RD_LAT)
    ) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_raw(flag_raw),
        .flag_dly(flag_dly)
    );

    rd_undef_lfsr #(
        .W   (DATA_W),
        .TAPS(TAPS),
        .SEED(SEED)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(flag_dly),
        .value  (rnd_val)
    );

    always_comb begin
        rdata_out = flag_dly ? rnd_val : mem_rdata;
    end

endmodule

// File: rtl/rd_undef_scrambler_chk.sv
module rd_undef_scrambler_chk #(
    parameter int DEPTH    = 12,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16,
    parameter int RD_LAT   = 1,
    parameter bit OOB_LIVE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] rdata_out,
    input logic              flag_raw,
    input logic              flag_dly,
    input logic [DATA_W-1:0] rnd_val
);
    localparam logic [ADDR_W:0] LIMIT = DEPTH[ADDR_W:0];

    p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_dly |-> rdata_out == mem_rdata);

    p_rand_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_dly |-> rdata_out == rnd_val);

    p_lfsr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_dly |=> rnd_val != $past(rnd_val));

    p_lfsr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_dly |=> $stable(rnd_val));

    p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_val != '0);

    generate
        if (RD_LAT == 1) begin : g_lat1
            p_delay_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
                flag_raw |=> flag_dly);
            p_delay_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !flag_raw |=> !flag_dly);
            if (OOB_LIVE) begin : g_oob
                p_oob_r1: assert property (@(posedge clk) disable iff (!rst_n)
                    (rd_en && ({1'b0, rd_addr} >= LIMIT)) |=> flag_dly);
            end
        end else begin : g_lat0
            p_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
                flag_raw == flag_dly);
        end
    endgenerate

endmodule

bind rd_undef_scrambler rd_undef_scrambler_chk #(
    .DEPTH   (DEPTH),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RD_LAT  (RD_LAT),
    .OOB_LIVE(OOB_LIVE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .mem_rdata(mem_rdata),
    .rdata_out(rdata_out),
    .flag_raw (flag_raw),
    .flag_dly (flag_dly),
    .rnd_val  (rnd_val)
);

// File: tb/rd_undef_scrambler_tb.sv
module rd_undef_scrambler_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          NVEC       = 12;
    localparam logic [15:0] TAPS_M     = 16'hB400;
    localparam logic [15:0] SEED_M     = 16'hACE1;

    // {rd_en, rd_addr[4], wr_act[2], wa0[4], wa1[4], mdata[16], flag_lat1, flag_lat0}
    localparam logic [32:0] VECS [NVEC] = '{
        {1'b1, 4'd3,  2'b00, 4'd3,  4'd3,  16'h1111, 1'b0, 1'b0},
        {1'b1, 4'd11, 2'b00, 4'd0,  4'd0,  16'h2222, 1'b0, 1'b0},
        {1'b1, 4'd12, 2'b00, 4'd0,  4'd0,  16'h3333, 1'b1, 1'b1},
        {1'b1, 4'd15, 2'b00, 4'd0,  4'd0,  16'h4444, 1'b1, 1'b1},
        {1'b0, 4'd2,  2'b00, 4'd0,  4'd0,  16'h5555, 1'b1, 1'b0},
        {1'b0, 4'd13, 2'b00, 4'd0,  4'd0,  16'h6666, 1'b1, 1'b0},
        {1'b1, 4'd5,  2'b01, 4'd5,  4'd0,  16'h7777, 1'b1, 1'b0},
        {1'b1, 4'd5,  2'b10, 4'd5,  4'd5,  16'h8888, 1'b1, 1'b0},
        {1'b1, 4'd5,  2'b11, 4'd4,  4'd6,  16'h9999, 1'b0, 1'b0},
        {1'b1, 4'd6,  2'b10, 4'd6,  4'd7,  16'hAAAA, 1'b0, 1'b0},
        {1'b1, 4'd0,  2'b00, 4'd0,  4'd0,  16'hBBBB, 1'b0, 1'b0},
        {1'b1, 4'd13, 2'b11, 4'd13, 4'd13, 16'hCCCC, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b1;
    logic [3:0]  rd_addr = '0;
    logic [15:0] mem_rdata = '0;
    logic [1:0]  wr_act = '0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] out1;
    logic [15:0] out0;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] lfsr1_m = SEED_M;
    logic [15:0] lfsr0_m = SEED_M;

    always #(CLK_PERIOD/2) clk = ~clk;

    rd_undef_scrambler u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .mem_rdata(mem_rdata), .wr_act(wr_act), .wr_addr(wr_addr), .rdata_out(out1)
    );

    rd_undef_scrambler #(.RD_LAT(0), .DIS_EN(1'b0)) u_lat0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .mem_rdata(mem_rdata), .wr_act(wr_act), .wr_addr(wr_addr), .rdata_out(out0)
    );

    function automatic logic [15:0] step(input logic [15:0] s);
        return {s[14:0], ^(s & TAPS_M)};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [32:0] v);
        rd_en     = v[32];
        rd_addr   = v[31:28];
        wr_act    = v[27:26];
        wr_addr   = {v[21:18], v[25:22]};
        mem_rdata = v[17:2];
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rd_addr = 4'd1;
        mem_rdata = 16'h1234;
        #1;
        check("R7 reset clears delayed flag", out1, 16'h1234);
        check("R4 reset pass-through lat0", out0, 16'h1234);

        // Table: each vector is checked on the zero-latency instance in the same
        // cycle and on the one-cycle instance after the next rising edge.
        for (int i = 0; i < NVEC; i++) begin
            logic f1;
            logic f0;
            logic [15:0] md;
            f1 = VECS[i][1];
            f0 = VECS[i][0];
            md = VECS[i][17:2];
            drive(VECS[i]);
            #1;
            check($sformatf("R5 R1 R8 lat0 vec%0d", i), out0, f0 ? lfsr0_m : md);
            @(posedge clk);
            if (f0) lfsr0_m = step(lfsr0_m);
            @(negedge clk);
            #1;
            check($sformatf("R1 R2 R3 R4 R6 lat1 vec%0d", i), out1, f1 ? lfsr1_m : md);
            if (f1) lfsr1_m = step(lfsr1_m);
        end

        // Directed: reset in the middle of a randomized stretch (R7)
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 4'd14; wr_act = '0; mem_rdata = 16'h0000;
        @(posedge clk);
        @(negedge clk);
        rd_addr = 4'd1; mem_rdata = 16'h5A5A;
        rst_n = 1'b0;
        #1;
        check("R7 async reset clears flag", out1, 16'h5A5A);
        @(negedge clk);
        rst_n = 1'b1;
        lfsr1_m = SEED_M;
        lfsr0_m = SEED_M;
        rd_addr = 4'd14; mem_rdata = 16'h0F0F;
        #1;
        check("R7 lat0 seed after reset", out0, SEED_M);
        @(posedge clk);
        lfsr0_m = step(lfsr0_m);
        @(negedge clk);
        #1;
        check("R7 lat1 seed after reset", out1, SEED_M);
        check("R6 lat0 stepped once", out0, lfsr0_m);
        lfsr1_m = step(lfsr1_m);

        // Directed: held in-range read, shift register must hold (R6)
        rd_addr = 4'd4; mem_rdata = 16'h0BAD;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        rd_addr = 4'd12;
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R6 state held across clean reads", out1, lfsr1_m);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule